// File: doc/BRIEF.md
# Memory Size Probe Sequencer

This block sits beside a memory controller and works out, without software help, which memory geometry is fitted. After a start pulse it walks a fixed list of candidate configurations, from the largest capacity down to the smallest. For each candidate it switches the controller off, loads the bank, timing and refresh settings through a register-write bus, waits out the device power-up time, switches the controller on, and waits again for the devices to settle. It then asks an external probe agent how many bytes respond from the base address. The first candidate whose probed size equals its own capacity ends the search.

When the dual-bank input is set at start, a hit on the first bank is followed by a bring-up of a second bank. That bank gets the same configuration, placed directly above the first one. If the second bank does not answer at full size, its configuration is cleared and the controller is switched off. When no candidate matches, the block finishes with a zero size and a no-memory flag. The wait lengths are derived from a clock-frequency parameter, so a bench can shorten them.

Top module: `mem_size_probe`

## Requirements
- R1: While reset is held and after it is released, busy, done, reg_we and probe_req are 0, and det_size, no_mem and bank1_ok are 0.
- R2: Candidates are tried largest first. The list gives size, row bits and configuration word: 128 MiB/13/0x000A4001, 64 MiB/13/0x00084001, 32 MiB/12/0x00062001, 16 MiB/12/0x00046001, 4 MiB/11/0x00008001.
- R3: Each attempt issues exactly these five writes, one per cycle and in this order. First, options (reg_addr 0) = 0. Then bank-0 configuration (reg_addr 1). Then timing (reg_addr 2) = 0x0086400D, or 0x01074015 when CLK_HZ is above 100 MHz. Then refresh (reg_addr 3). Last, options = 0x80800000. No register write happens outside a run.
- R4: The refresh word is floor(floor(floor(REFRESH_MS·10^6 / 2^rows) · floor(CLK_HZ/1000)) / 10^6), ANDed with 0x3FF8 and shifted left by 16.
- R5: At least CLK_HZ·PWUP_US/10^6 clocks pass between the refresh write and the enable write of the same attempt.
- R6: At least CLK_HZ·SETTLE_US/10^6 clocks pass between an enable write and the following rise of probe_req.
- R7: probe_req stays high, with probe_base and probe_len stable, until probe_ack. Bank-0 probes use base 0 and length equal to the candidate size. When probe_found equals probe_len the search stops and det_size takes that size.
- R8: If all candidates miss, done is raised with det_size = 0 and no_mem = 1.
- R9: When dual_bank was 1 at start and bank 0 hits, the block writes options = 0, then bank-1 configuration (reg_addr 4) = configuration word OR size, then options = 0x80800000. It waits as in R6, then probes with base and length both equal to the bank-0 size. On a match, bank1_ok = 1.
- R10: If the bank-1 probe misses, the block writes bank-1 configuration = 0 and then options = 0. bank1_ok stays 0 and det_size keeps the bank-0 size.
- R11: done is a one-cycle pulse. A start pulse while busy has no effect on the run's write sequence or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (ignored while busy) |
| dual_bank | input | 1 | Also bring up the second bank (sampled at start) |
| probe_ack | input | 1 | Probe agent has a result this cycle |
| probe_found | input | 32 | Number of bytes that responded |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| det_size | output | 32 | Detected bank-0 size in bytes, 0 if none |
| no_mem | output | 1 | No candidate matched |
| bank1_ok | output | 1 | Second bank answered at full size |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | 3 | Register select (0 options, 1 bank 0, 2 timing, 3 refresh, 4 bank 1) |
| reg_wdata | output | 32 | Register write data |
| probe_req | output | 1 | Probe request, held until acknowledged |
| probe_base | output | 32 | Byte address where the probe starts |
| probe_len | output | 32 | Expected size in bytes |

## Verification
The assertions assume a well-behaved probe agent. It answers every request once, with a single-cycle acknowledge. It raises that acknowledge only while a request is pending. Its reported count never exceeds the requested length. The bench's responder has exactly these properties: it waits a random one to four cycles, pulses probe_ack for one cycle, and returns the smaller of the requested length and the capacity fitted at the requested base. Installed capacities are drawn at random from the candidate sizes, from values in between, and from values below the smallest candidate. Directed cases cover the largest-size hit, the full miss, a second-bank pass, a second-bank failure, and a start pulse issued mid-run.

// File: rtl/msp_pkg.sv
package msp_pkg;

    localparam int CAND_COUNT = 5;
    localparam logic [31:0] OPT_ENABLE = 32'h8080_0000;

    typedef enum logic [2:0] {
        RA_OPTS    = 3'd0,
        RA_BANK0   = 3'd1,
        RA_TIMING  = 3'd2,
        RA_REFRESH = 3'd3,
        RA_BANK1   = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [31:0] size;
        logic [4:0]  rows;
        logic [31:0] cfg;
    } cand_t;

    typedef enum logic [4:0] {
        ST_IDLE, ST_OFF, ST_BANK0, ST_TIMING, ST_REFRESH, ST_PWUP,
        ST_ON, ST_SETTLE, ST_PROBE,
        ST_B1_OFF, ST_B1_CFG, ST_B1_ON, ST_B1_SETTLE, ST_B1_PROBE,
        ST_B1_CLR, ST_B1_STOP, ST_FINISH
    } state_e;

    // Candidate list, largest capacity first.
    function automatic cand_t cand_entry(int idx);
        cand_t c;
        case (idx)
            0:       c = '{size: 32'h0800_0000, rows: 5'd13, cfg: 32'h000A_4001};
            1:       c = '{size: 32'h0400_0000, rows: 5'd13, cfg: 32'h0008_4001};
            2:       c = '{size: 32'h0200_0000, rows: 5'd12, cfg: 32'h0006_2001};
            3:       c = '{size: 32'h0100_0000, rows: 5'd12, cfg: 32'h0004_6001};
            4:       c = '{size: 32'h0040_0000, rows: 5'd11, cfg: 32'h0000_8001};
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic logic [31:0] refresh_word(longint clk_hz, longint ms, int rows);
        longint t;
        t = (ms * 64'd1000000) / (64'd1 << rows);
        t = t * (clk_hz / 1000);
        t = t / 1000000;
        return 32'((t & 64'h3FF8) << 16);
    endfunction

    function automatic logic [31:0] timing_word(longint clk_hz);
        return (clk_hz > 100000000) ? 32'h0107_4015 : 32'h0086_400D;
    endfunction

    function automatic int wait_cycles(longint clk_hz, longint us);
        longint c;
        c = (clk_hz * us) / 1000000;
        return (c < 1) ? 1 : int'(c);
    endfunction

endpackage

// File: rtl/msp_timer.sv
module msp_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (load)      cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/msp_cand_rom.sv
module msp_cand_rom
    import msp_pkg::*;
#(
    parameter int N_CAND     = CAND_COUNT,
    parameter int CLK_HZ     = 100000000,
    parameter int REFRESH_MS = 64,
    parameter int IW         = (N_CAND > 1) ? $clog2(N_CAND) : 1
) (
    input  logic [IW-1:0] idx,
    output cand_t         cand,
    output logic [31:0]   refresh
);
    cand_t       tab     [N_CAND];
    logic [31:0] ref_tab [N_CAND];

    for (genvar g = 0; g < N_CAND; g++) begin : g_ent
        localparam cand_t E = cand_entry(g);
        assign tab[g]     = E;
        assign ref_tab[g] = refresh_word(CLK_HZ, REFRESH_MS, int'(E.rows));
    end

    assign cand    = tab[idx];
    assign refresh = ref_tab[idx];
endmodule

// File: rtl/mem_size_probe.sv
module mem_size_probe
    import msp_pkg::*;
#(
    parameter int N_CAND     = CAND_COUNT,
    parameter int CLK_HZ     = 100000000,
    parameter int REFRESH_MS = 64,
    parameter int PWUP_US    = 200,
    parameter int SETTLE_US  = 10000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        dual_bank,
    input  logic        probe_ack,
    input  logic [31:0] probe_found,
    output logic        busy,
    output logic        done,
    output logic [31:0] det_size,
    output logic        no_mem,
    output logic        bank1_ok,
    output logic        reg_we,
    output logic [2:0]  reg_addr,
    output logic [31:0] reg_wdata,
    output logic        probe_req,
    output logic [31:0] probe_base,
    output logic [31:0] probe_len
);
    localparam int IW         = (N_CAND > 1) ? $clog2(N_CAND) : 1;
    localparam int PWUP_CYC   = wait_cycles(CLK_HZ, PWUP_US);
    localparam int SETTLE_CYC = wait_cycles(CLK_HZ, SETTLE_US);
    localparam int MAX_CYC    = (PWUP_CYC > SETTLE_CYC) ? PWUP_CYC : SETTLE_CYC;
    localparam int TW         = $clog2(MAX_CYC + 1);
    localparam logic [31:0] TIME_WORD = timing_word(CLK_HZ);

    state_e      state;
    logic [IW-1:0] idx;
    logic        dual_q;
    logic [31:0] found_size;
    logic        no_mem_q, b1_ok_q;
    cand_t       cand;
    logic [31:0] refresh;
    logic        tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;
    reg_addr_e   addr_e;
    logic        hit, last;

    msp_cand_rom #(.N_CAND(N_CAND), .CLK_HZ(CLK_HZ), .REFRESH_MS(REFRESH_MS), .IW(IW)) u_rom (
        .idx(idx), .cand(cand), .refresh(refresh));

    msp_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_done));

    assign hit  = (probe_found == cand.size);
    assign last = (idx == IW'(N_CAND - 1));

    // Output decode: one register write per writing state.
    always_comb begin
        reg_we    = 1'b0;
        addr_e    = RA_OPTS;
        reg_wdata = '0;
        tmr_load  = 1'b0;
        tmr_val   = TW'(SETTLE_CYC - 1);
        case (state)
            ST_OFF, ST_B1_OFF, ST_B1_STOP: reg_we = 1'b1;
            ST_BANK0:   begin reg_we = 1'b1; addr_e = RA_BANK0;   reg_wdata = cand.cfg;  end
            ST_TIMING:  begin reg_we = 1'b1; addr_e = RA_TIMING;  reg_wdata = TIME_WORD; end
            ST_REFRESH: begin
                reg_we = 1'b1; addr_e = RA_REFRESH; reg_wdata = refresh;
                tmr_load = 1'b1; tmr_val = TW'(PWUP_CYC - 1);
            end
            ST_ON, ST_B1_ON: begin
                reg_we = 1'b1; reg_wdata = OPT_ENABLE; tmr_load = 1'b1;
            end
            ST_B1_CFG:  begin reg_we = 1'b1; addr_e = RA_BANK1; reg_wdata = cand.cfg | cand.size; end
            ST_B1_CLR:  begin reg_we = 1'b1; addr_e = RA_BANK1; end
            default: ;
        endcase
    end

    assign reg_addr   = addr_e;
    assign probe_req  = (state == ST_PROBE) || (state == ST_B1_PROBE);
    assign probe_base = (state == ST_B1_PROBE) ? cand.size : '0;
    assign probe_len  = cand.size;
    assign busy       = (state != ST_IDLE);
    assign done       = (state == ST_FINISH);
    assign det_size   = found_size;
    assign no_mem     = no_mem_q;
    assign bank1_ok   = b1_ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            idx        <= '0;
            dual_q     <= 1'b0;
            found_size <= '0;
            no_mem_q   <= 1'b0;
            b1_ok_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state      <= ST_OFF;
                    idx        <= '0;
                    dual_q     <= dual_bank;
                    found_size <= '0;
                    no_mem_q   <= 1'b0;
                    b1_ok_q    <= 1'b0;
                end
                ST_OFF:     state <= ST_BANK0;
                ST_BANK0:   state <= ST_TIMING;
                ST_TIMING:  state <= ST_REFRESH;
                ST_REFRESH: state <= ST_PWUP;
                ST_PWUP:    if (tmr_done) state <= ST_ON;
                ST_ON:      state <= ST_SETTLE;
                ST_SETTLE:  if (tmr_done) state <= ST_PROBE;
                ST_PROBE: if (probe_ack) begin
                    if (hit) begin
                        found_size <= cand.size;
                        state      <= dual_q ? ST_B1_OFF : ST_FINISH;
                    end else if (last) begin
                        no_mem_q <= 1'b1;
                        state    <= ST_FINISH;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= ST_OFF;
                    end
                end
                ST_B1_OFF:    state <= ST_B1_CFG;
                ST_B1_CFG:    state <= ST_B1_ON;
                ST_B1_ON:     state <= ST_B1_SETTLE;
                ST_B1_SETTLE: if (tmr_done) state <= ST_B1_PROBE;
                ST_B1_PROBE: if (probe_ack) begin
                    if (hit) begin
                        b1_ok_q <= 1'b1;
                        state   <= ST_FINISH;
                    end else begin
                        state <= ST_B1_CLR;
                    end
                end
                ST_B1_CLR:  state <= ST_B1_STOP;
                ST_B1_STOP: state <= ST_FINISH;
                default:    state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/msp_checker.sv
module msp_checker #(
    parameter int PWUP_CYC   = 1,
    parameter int SETTLE_CYC = 1
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        no_mem,
    input logic [31:0] det_size,
    input logic        reg_we,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        probe_req,
    input logic        probe_ack,
    input logic [31:0] probe_len
);
    logic [31:0] gap;
    logic [2:0]  last_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap       <= '0;
            last_addr <= '0;
        end else if (reg_we) begin
            gap       <= '0;
            last_addr <= reg_addr;
        end else if (gap != 32'hFFFF_FFFF) begin
            gap <= gap + 1;
        end
    end

    a_r3_write_busy: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> busy);

    a_r5_pwup_gap: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 3'd0 && reg_wdata == 32'h8080_0000 && last_addr == 3'd3)
        |-> gap >= 32'(PWUP_CYC));

    a_r6_settle_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(probe_req) |-> gap >= 32'(SETTLE_CYC));

    a_r7_probe_hold: assert property (@(posedge clk) disable iff (rst)
        (probe_req && !probe_ack) |=> (probe_req && $stable(probe_len)));

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && probe_req));

    a_r8_fail_zero: assert property (@(posedge clk) disable iff (rst)
        (done && no_mem) |-> det_size == 32'd0);

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind mem_size_probe msp_checker #(.PWUP_CYC(PWUP_CYC), .SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .no_mem(no_mem),
    .det_size(det_size), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .probe_req(probe_req), .probe_ack(probe_ack),
    .probe_len(probe_len));

// File: tb/tb_mem_size_probe.sv
module tb_mem_size_probe;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 100000000;
    localparam int PW_CYC     = 200;   // 2 us at 100 MHz
    localparam int ST_CYC     = 2000;  // 20 us at 100 MHz
    localparam logic [31:0] EN_WORD = 32'h8080_0000;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, dual_bank = 1'b0;
    logic probe_ack = 1'b0;
    logic [31:0] probe_found = '0;
    logic busy, done, no_mem, bank1_ok, reg_we, probe_req;
    logic [31:0] det_size, reg_wdata, probe_base, probe_len;
    logic [2:0]  reg_addr;

    int n_chk = 0, n_err = 0;
    longint cyc = 0;
    logic [31:0] mem0 = '0, mem1 = '0;

    logic [2:0]  w_addr [64];
    logic [31:0] w_data [64];
    longint      w_cyc  [64];
    int          wn = 0;
    logic [31:0] p_base [16];
    logic [31:0] p_len  [16];
    longint      p_cyc  [16];
    int          pn = 0;
    logic        prev_req = 1'b0;
    int          ack_wait = 0;

    mem_size_probe #(.CLK_HZ(CLK_HZ), .PWUP_US(2), .SETTLE_US(20)) dut (
        .clk(clk), .rst(rst), .start(start), .dual_bank(dual_bank),
        .probe_ack(probe_ack), .probe_found(probe_found), .busy(busy), .done(done),
        .det_size(det_size), .no_mem(no_mem), .bank1_ok(bank1_ok), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .probe_req(probe_req),
        .probe_base(probe_base), .probe_len(probe_len));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] t_size(int k);
        return 32'h0800_0000 >> (k == 4 ? 5 : k);
    endfunction
    function automatic int t_rows(int k);
        return (k < 2) ? 13 : (k < 4) ? 12 : 11;
    endfunction
    function automatic logic [31:0] t_cfg(int k);
        case (k)
            0: return 32'h000A_4001;
            1: return 32'h0008_4001;
            2: return 32'h0006_2001;
            3: return 32'h0004_6001;
            default: return 32'h0000_8001;
        endcase
    endfunction
    function automatic logic [31:0] t_refresh(int rows);
        longint per_row, ticks;
        per_row = 64000000 / (longint'(1) << rows);
        ticks   = (per_row * (CLK_HZ / 1000)) / 1000000;
        return 32'((ticks & 64'h3FF8) << 16);
    endfunction

    // Probe agent model and monitors, all at the falling edge.
    always @(negedge clk) begin
        if (rst) begin
            probe_ack = 1'b0; ack_wait = 0;
        end else if (probe_ack) begin
            probe_ack = 1'b0;
        end else if (probe_req) begin
            if (ack_wait == 0) ack_wait = 1 + int'($urandom % 4);
            else begin
                ack_wait--;
                if (ack_wait == 0) begin
                    probe_ack = 1'b1;
                    if (probe_base == 0) probe_found = (mem0 >= probe_len) ? probe_len : mem0;
                    else                 probe_found = (mem1 >= probe_len) ? probe_len : mem1;
                end
            end
        end
        if (!rst && reg_we && wn < 64) begin
            w_addr[wn] = reg_addr; w_data[wn] = reg_wdata; w_cyc[wn] = cyc; wn++;
        end
        if (!rst && probe_req && !prev_req && pn < 16) begin
            p_base[pn] = probe_base; p_len[pn] = probe_len; p_cyc[pn] = cyc; pn++;
        end
        prev_req = probe_req;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_case(input logic [31:0] i0, input logic [31:0] i1,
                            input bit dual, input bit mid_start);
        logic [2:0]  ea [64];
        logic [31:0] ed [64];
        logic [31:0] eb [16];
        logic [31:0] el [16];
        int en = 0, epn = 0, hit = -1, tries, cnt = 0, bad;
        logic [31:0] s, got_size;
        logic got_nm, got_b1, exp_b1;
        mem0 = i0; mem1 = i1; wn = 0; pn = 0;
        @(negedge clk); start = 1'b1; dual_bank = dual;
        @(negedge clk); start = 1'b0;
        while (!done && cnt < 40000) begin
            @(negedge clk); cnt++;
            start = (mid_start && cnt == 30);
        end
        chk(cnt < 40000, "R7", "run finished before watchdog", 32'(cnt), 32'd40000);
        got_size = det_size; got_nm = no_mem; got_b1 = bank1_ok;
        @(negedge clk);
        chk(!done && !busy, "R11", "done is a single pulse and run ends",
            {30'd0, done, busy}, 32'd0);

        for (int k = 0; k < 5; k++) if (hit < 0 && t_size(k) <= i0) hit = k;
        tries = (hit < 0) ? 5 : hit + 1;
        for (int k = 0; k < tries; k++) begin
            ea[en] = 3'd0; ed[en] = 32'd0;              en++;
            ea[en] = 3'd1; ed[en] = t_cfg(k);           en++;
            ea[en] = 3'd2; ed[en] = 32'h0086_400D;      en++;
            ea[en] = 3'd3; ed[en] = t_refresh(t_rows(k)); en++;
            ea[en] = 3'd0; ed[en] = EN_WORD;            en++;
            eb[epn] = 32'd0; el[epn] = t_size(k); epn++;
        end
        exp_b1 = 1'b0;
        if (hit >= 0 && dual) begin
            s = t_size(hit);
            ea[en] = 3'd0; ed[en] = 32'd0;        en++;
            ea[en] = 3'd4; ed[en] = t_cfg(hit) | s; en++;
            ea[en] = 3'd0; ed[en] = EN_WORD;      en++;
            eb[epn] = s; el[epn] = s; epn++;
            exp_b1 = (i1 >= s);
            if (!exp_b1) begin
                ea[en] = 3'd4; ed[en] = 32'd0; en++;
                ea[en] = 3'd0; ed[en] = 32'd0; en++;
            end
        end

        chk(got_size == ((hit < 0) ? 32'd0 : t_size(hit)), "R7", "detected size",
            got_size, (hit < 0) ? 32'd0 : t_size(hit));
        chk(got_nm == (hit < 0), "R8", "no_mem flag", {31'd0, got_nm}, {31'd0, hit < 0});
        chk(got_b1 == exp_b1, dual ? "R9" : "R10", "bank1_ok", {31'd0, got_b1}, {31'd0, exp_b1});
        chk(wn == en, "R3", "write count", 32'(wn), 32'(en));
        chk(pn == epn, "R7", "probe count", 32'(pn), 32'(epn));
        if (wn == en) begin
            bad = -1;
            for (int k = 0; k < en; k++)
                if (bad < 0 && (w_addr[k] != ea[k] || w_data[k] != ed[k])) bad = k;
            chk(bad < 0, "R2 R3 R4 R9 R10", "write sequence entry",
                (bad < 0) ? 32'd0 : {w_addr[bad], w_data[bad][28:0]},
                (bad < 0) ? 32'd0 : {ea[bad], ed[bad][28:0]});
        end
        if (pn == epn) begin
            bad = -1;
            for (int k = 0; k < epn; k++)
                if (bad < 0 && (p_base[k] != eb[k] || p_len[k] != el[k])) bad = k;
            chk(bad < 0, "R7 R9", "probe base/len", (bad < 0) ? 32'd0 : p_base[bad],
                (bad < 0) ? 32'd0 : eb[bad]);
        end
        if (wn == en && pn == epn) begin
            for (int k = 0; k < tries; k++) begin
                chk(w_cyc[5*k+4] - w_cyc[5*k+3] >= PW_CYC, "R5", "power-up gap",
                    32'(w_cyc[5*k+4] - w_cyc[5*k+3]), 32'(PW_CYC));
                chk(p_cyc[k] - w_cyc[5*k+4] >= ST_CYC, "R6", "settle gap",
                    32'(p_cyc[k] - w_cyc[5*k+4]), 32'(ST_CYC));
            end
            if (epn > tries)
                chk(p_cyc[tries] - w_cyc[5*tries+2] >= ST_CYC, "R6", "bank-1 settle gap",
                    32'(p_cyc[tries] - w_cyc[5*tries+2]), 32'(ST_CYC));
        end
    endtask

    function automatic logic [31:0] pick_size(int r);
        case (r % 8)
            0: return 32'h0800_0000;
            1: return 32'h0400_0000;
            2: return 32'h0300_0000;
            3: return 32'h0200_0000;
            4: return 32'h0100_0000;
            5: return 32'h0080_0000;
            6: return 32'h0040_0000;
            default: return 32'h0020_0000;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !reg_we && !probe_req, "R1", "control outputs in reset",
            {28'd0, busy, done, reg_we, probe_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(det_size == 0 && !no_mem && !bank1_ok && !busy, "R1", "results after reset",
            det_size, 32'd0);
        repeat (5) @(negedge clk);
        chk(!reg_we, "R3", "no write while idle", {31'd0, reg_we}, 32'd0);

        run_case(32'h0800_0000, 32'd0, 1'b0, 1'b0);          // R2: largest first
        run_case(32'h0020_0000, 32'd0, 1'b0, 1'b0);          // R8: all miss
        run_case(32'h0140_0000, 32'h0140_0000, 1'b1, 1'b0);  // R9: 16 MiB + bank 1
        run_case(32'h0400_0000, 32'd0, 1'b1, 1'b1);          // R10, R11
        for (int n = 0; n < 3; n++)
            run_case(pick_size(int'($urandom)), pick_size(int'($urandom)),
                     1'($urandom % 2), 1'b0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(longint'(CLK_PERIOD) * 190000);
        n_err++; n_chk++;
        $display("FAIL R7 watchdog expired: actual=%0d expected=%0d", cyc, 190000);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule